// File: doc/BRIEF.md
# Prescaled Match Timer

A 32-bit free-running timer for a peripheral subsystem. A prescale counter runs on the peripheral clock and divides it by a programmable amount. Each time the prescaler wraps, a timer counter advances by one. Four match channels compare their match values with the timer counter on every clock. Each channel has a 3-bit action field. On a match the field can raise an interrupt flag, restart the timer counter from zero, or halt counting.

Software reaches every register through a simple word-addressed bus. A write completes in one clock, and read data is combinational from the address. Interrupt flags are cleared by writing ones. A single interrupt line goes high whenever any flag is pending. A typical use is periodic sampling: set the prescaler and a match value, enable restart and interrupt on that channel, then enable the timer.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0 and `irqOut` is 0.
- R2: Counting is enabled and no control bit intervenes. In this state the prescale counter (address 3) increments every clock. In the clock after it equals the prescale value (address 2), it returns to 0 and the timer counter (address 4) increments. The timer counter therefore advances once every PR+1 clocks.
- R3: The control register is at address 0. While its bit 0 (enable) is 0, neither counter changes unless the bus writes it.
- R4: While control bit 1 (counter clear) is 1, both counters are held at 0 from the clock after the write onward, even if bit 0 is set.
- R5: The match control register is at address 5. Only bits [11:0] are stored, and bits [15:12] and above read as 0. Match values for channels 0 to 3 are at addresses 6 to 9 and read back as written.
- R6: Channel i's field occupies match control bits [3i+2:3i]. If bit 3i is set, interrupt flag i is set on the clock after the timer counter first equals match value i. A match value that stays equal raises the flag only once.
- R7: If match control bit 3i+1 is set, a timer tick taken while the timer counter equals match value i loads 0 instead of incrementing. This gives a period of MR+1 ticks.
- R8: If match control bit 3i+2 is set, the first match on channel i blocks that clock's count. The same match also clears control bit 0, so the timer counter stays at the match value.
- R9: The interrupt register is at address 1, and bit i belongs to channel i. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged. When a new match sets a flag in the same clock as a clearing write to it, the flag ends up set.
- R10: `irqOut` is 1 exactly when at least one interrupt flag is set.
- R11: A bus write to address 3 or 4 loads that counter with the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Word address of register |
| busWrEn | input | 1 | Write strobe, captured on the rising edge |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for `busAddr` (combinational) |
| irqOut | output | 1 | Any interrupt flag pending |

## Verification
Two things can land on the same clock: a channel's match setting its interrupt flag, and a software write of 1 that clears that flag. The bench counts clocks from the enabling write. It then places the clearing write on exactly the edge where the match flag is registered. The flag must read back as set afterward. A second pairing is a stop-on-match against the counter's own advance. The bench judges it by the timer counter holding the match value and the enable bit reading 0.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int DW = 32;          // counter and register width
  localparam int NCH = 4;          // match channels
  localparam int FLD = 3;          // action bits per channel
  localparam int MCRW = 16;        // architectural match control width
  localparam int MCR_USED = NCH * FLD;
  localparam int AW = 4;           // bus word address width

  localparam logic [AW-1:0] ADDR_CTRL   = AW'(0);
  localparam logic [AW-1:0] ADDR_IRQ    = AW'(1);
  localparam logic [AW-1:0] ADDR_PRE    = AW'(2);
  localparam logic [AW-1:0] ADDR_PCNT   = AW'(3);
  localparam logic [AW-1:0] ADDR_TCNT   = AW'(4);
  localparam logic [AW-1:0] ADDR_MCTL   = AW'(5);
  localparam logic [AW-1:0] ADDR_MATCH0 = AW'(6);

  // strobes from control to datapath
  typedef struct packed {
    logic          run;
    logic          clear;
    logic          ldPc;
    logic          ldTc;
    logic [DW-1:0] ldVal;
  } cntStrobe_t;
endpackage

// File: rtl/timer_dp.sv
module timer_dp
  import mtimer_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  cntStrobe_t              strobe,
  input  logic [DW-1:0]           prescale,
  input  logic [NCH-1:0][DW-1:0]  matchVal,
  input  logic [NCH-1:0]          rstOnMatch,
  input  logic [NCH-1:0]          stopOnMatch,
  output logic [DW-1:0]           pcVal,
  output logic [DW-1:0]           tcVal,
  output logic [NCH-1:0]          matchEvt
);
  logic [NCH-1:0] hit;
  logic [NCH-1:0] hitPrev;
  logic           stopNow;
  logic           rstNow;
  logic           advance;
  logic           tick;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_cmp
    assign hit[gi] = (tcVal == matchVal[gi]);
  end

  // an event is the first cycle of equality
  assign matchEvt = hit & ~hitPrev;
  assign stopNow  = |(matchEvt & stopOnMatch);
  assign rstNow   = |(hit & rstOnMatch);
  assign advance  = strobe.run && !stopNow;
  assign tick     = advance && (pcVal == prescale);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitPrev <= '0;
    end else begin
      hitPrev <= hit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcVal <= '0;
      tcVal <= '0;
    end else if (strobe.clear) begin
      pcVal <= '0;
      tcVal <= '0;
    end else begin
      if (strobe.ldPc) begin
        pcVal <= strobe.ldVal;
      end else if (advance) begin
        pcVal <= tick ? '0 : pcVal + 1'b1;
      end
      if (strobe.ldTc) begin
        tcVal <= strobe.ldVal;
      end else if (tick) begin
        tcVal <= rstNow ? '0 : tcVal + 1'b1;
      end
    end
  end
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import mtimer_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [AW-1:0]           busAddr,
  input  logic                    busWrEn,
  input  logic [DW-1:0]           busWData,
  output logic [DW-1:0]           busRData,
  input  logic [DW-1:0]           pcVal,
  input  logic [DW-1:0]           tcVal,
  input  logic [NCH-1:0]          matchEvt,
  output cntStrobe_t              strobe,
  output logic [DW-1:0]           prescale,
  output logic [NCH-1:0][DW-1:0]  matchVal,
  output logic [NCH-1:0]          intEnable,
  output logic [NCH-1:0]          rstOnMatch,
  output logic [NCH-1:0]          stopOnMatch,
  output logic [NCH-1:0]          irqFlags
);
  logic                enReg;
  logic                clrReg;
  logic [MCR_USED-1:0] mcrReg;
  logic                stopHit;

  logic wrCtrl, wrIrq, wrPre, wrMctl;
  assign wrCtrl = busWrEn && (busAddr == ADDR_CTRL);
  assign wrIrq  = busWrEn && (busAddr == ADDR_IRQ);
  assign wrPre  = busWrEn && (busAddr == ADDR_PRE);
  assign wrMctl = busWrEn && (busAddr == ADDR_MCTL);

  for (genvar gi = 0; gi < NCH; gi++) begin : g_fld
    assign intEnable[gi]   = mcrReg[FLD*gi];
    assign rstOnMatch[gi]  = mcrReg[FLD*gi+1];
    assign stopOnMatch[gi] = mcrReg[FLD*gi+2];
  end

  assign stopHit = |(matchEvt & stopOnMatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      clrReg   <= 1'b0;
      prescale <= '0;
      mcrReg   <= '0;
    end else begin
      if (wrCtrl) begin
        enReg  <= busWData[0];
        clrReg <= busWData[1];
      end
      if (stopHit) begin
        enReg <= 1'b0;            // hardware stop wins
      end
      if (wrPre)  prescale <= busWData;
      if (wrMctl) mcrReg   <= busWData[MCR_USED-1:0];
    end
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    logic wrMatch;
    assign wrMatch = busWrEn && (busAddr == ADDR_MATCH0 + AW'(gi));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        matchVal[gi] <= '0;
        irqFlags[gi] <= 1'b0;
      end else begin
        if (wrMatch) matchVal[gi] <= busWData;
        // set has priority over write-one clear
        irqFlags[gi] <= (irqFlags[gi] && !(wrIrq && busWData[gi]))
                        || (matchEvt[gi] && intEnable[gi]);
      end
    end
  end

  always_comb begin
    strobe.run   = enReg && !clrReg;
    strobe.clear = clrReg;
    strobe.ldPc  = busWrEn && (busAddr == ADDR_PCNT);
    strobe.ldTc  = busWrEn && (busAddr == ADDR_TCNT);
    strobe.ldVal = busWData;
  end

  always_comb begin
    busRData = '0;
    case (busAddr)
      ADDR_CTRL: busRData = {{(DW-2){1'b0}}, clrReg, enReg};
      ADDR_IRQ:  busRData = {{(DW-NCH){1'b0}}, irqFlags};
      ADDR_PRE:  busRData = prescale;
      ADDR_PCNT: busRData = pcVal;
      ADDR_TCNT: busRData = tcVal;
      ADDR_MCTL: busRData = {{(DW-MCR_USED){1'b0}}, mcrReg};
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (busAddr == ADDR_MATCH0 + AW'(i)) busRData = matchVal[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtimer_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [DW-1:0] busWData,
  output logic [DW-1:0] busRData,
  output logic          irqOut
);
  cntStrobe_t             strobe;
  logic [DW-1:0]          prescale;
  logic [NCH-1:0][DW-1:0] matchVal;
  logic [NCH-1:0]         intEnable;
  logic [NCH-1:0]         rstOnMatch;
  logic [NCH-1:0]         stopOnMatch;
  logic [NCH-1:0]         irqFlags;
  logic [NCH-1:0]         matchEvt;
  logic [DW-1:0]          pcVal;
  logic [DW-1:0]          tcVal;

  timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWData(busWData), .busRData(busRData),
    .pcVal(pcVal), .tcVal(tcVal), .matchEvt(matchEvt),
    .strobe(strobe), .prescale(prescale), .matchVal(matchVal),
    .intEnable(intEnable), .rstOnMatch(rstOnMatch), .stopOnMatch(stopOnMatch),
    .irqFlags(irqFlags)
  );

  timer_dp u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .prescale(prescale), .matchVal(matchVal),
    .rstOnMatch(rstOnMatch), .stopOnMatch(stopOnMatch),
    .pcVal(pcVal), .tcVal(tcVal), .matchEvt(matchEvt)
  );

  assign irqOut = |irqFlags;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
  import mtimer_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] busAddr,
  input logic          busWrEn,
  input logic [DW-1:0] busWData,
  input logic          run,
  input logic          clear,
  input logic          ldTc,
  input logic [DW-1:0] prescale,
  input logic [DW-1:0] pcVal,
  input logic [DW-1:0] tcVal,
  input logic [NCH-1:0] matchEvt,
  input logic [NCH-1:0] intEnable,
  input logic [NCH-1:0] stopOnMatch,
  input logic [NCH-1:0] irqFlags
);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !clear && !ldTc) |=> $stable(tcVal));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (pcVal == '0 && tcVal == '0));

  // R2
  prescale_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !clear && !ldTc && pcVal != prescale) |=> $stable(tcVal));

  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((matchEvt & intEnable) != '0) |=>
      ((irqFlags & $past(matchEvt & intEnable)) == $past(matchEvt & intEnable)));

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_IRQ && (matchEvt & intEnable) == '0) |=>
      ((irqFlags & $past(busWData[NCH-1:0])) == '0));

  // R8
  stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((matchEvt & stopOnMatch) != '0) && !ldTc && !clear) |=> (!run && $stable(tcVal)));
endmodule

bind match_timer match_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWData(busWData),
  .run(strobe.run), .clear(strobe.clear), .ldTc(strobe.ldTc),
  .prescale(prescale), .pcVal(pcVal), .tcVal(tcVal), .matchEvt(matchEvt),
  .intEnable(intEnable), .stopOnMatch(stopOnMatch), .irqFlags(irqFlags)
);

// File: tb/tb_match_timer.sv
module tb_match_timer;
  localparam logic [3:0] A_CTRL = 4'd0, A_IRQ = 4'd1, A_PRE = 4'd2, A_PC = 4'd3,
                         A_TC = 4'd4, A_MCTL = 4'd5, A_MR0 = 4'd6;

  typedef struct packed {
    logic [31:0] pre;
    logic [31:0] cyc;
    logic [31:0] expTc;
    logic [31:0] expPc;
  } vec_t;

  // prescale vectors: tc = floor(N/(p+1)), pc = N mod (p+1)
  localparam vec_t VEC [6] = '{
    '{32'd0, 32'd10, 32'd10, 32'd0},
    '{32'd1, 32'd10, 32'd5,  32'd0},
    '{32'd2, 32'd10, 32'd3,  32'd1},
    '{32'd4, 32'd23, 32'd4,  32'd3},
    '{32'd2, 32'd9,  32'd3,  32'd0},
    '{32'd1, 32'd7,  32'd3,  32'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  match_timer dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWData(busWData), .busRData(busRData), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      busRead(4'(a), rd);
      check("R1 reset reg", rd, 32'd0);
    end
    check("R1 irqOut", {31'd0, irqOut}, 32'd0);

    // R5 register map
    busWrite(A_MCTL, 32'hFFFF_FFFF);
    busRead(A_MCTL, rd);  check("R5 mctl width", rd, 32'h0000_0FFF);
    busWrite(A_MR0 + 4'd2, 32'h1234_5678);
    busRead(A_MR0 + 4'd2, rd); check("R5 match2", rd, 32'h1234_5678);
    busWrite(A_MCTL, 32'd0);
    busWrite(A_MR0 + 4'd2, 32'd0);

    // R11 loads, R3 hold while disabled
    busWrite(A_TC, 32'd100);
    busWrite(A_PC, 32'd5);
    busRead(A_TC, rd); check("R11 tc load", rd, 32'd100);
    busRead(A_PC, rd); check("R11 pc load", rd, 32'd5);
    repeat (5) @(negedge clk);
    busRead(A_TC, rd); check("R3 tc hold", rd, 32'd100);
    busRead(A_PC, rd); check("R3 pc hold", rd, 32'd5);

    // R2 prescale vector table
    foreach (VEC[i]) begin
      busWrite(A_CTRL, 32'd2);
      busWrite(A_PRE, VEC[i].pre);
      busWrite(A_CTRL, 32'd1);
      repeat (VEC[i].cyc) @(negedge clk);
      busRead(A_TC, rd); check("R2 tc", rd, VEC[i].expTc);
      busRead(A_PC, rd); check("R2 pc", rd, VEC[i].expPc);
    end

    // R6 interrupt on first match, channel 0
    busWrite(A_CTRL, 32'd2);
    busWrite(A_MR0, 32'd5);
    busWrite(A_MCTL, 32'h1);
    busWrite(A_PRE, 32'd0);
    busWrite(A_CTRL, 32'd1);
    repeat (5) @(negedge clk);
    busRead(A_TC, rd);  check("R6 tc at match", rd, 32'd5);
    busRead(A_IRQ, rd); check("R6 flag not yet", rd, 32'd0);
    @(negedge clk);
    busRead(A_IRQ, rd); check("R6 flag set", rd, 32'd1);
    check("R10 irqOut high", {31'd0, irqOut}, 32'd1);

    // R9 write zero keeps, write one clears, no re-raise
    busWrite(A_IRQ, 32'd0);
    busRead(A_IRQ, rd); check("R9 zero write keeps", rd, 32'd1);
    busWrite(A_IRQ, 32'd1);
    repeat (4) @(negedge clk);
    busRead(A_IRQ, rd); check("R6 once only / R9 cleared", rd, 32'd0);
    check("R10 irqOut low", {31'd0, irqOut}, 32'd0);

    // R9 set wins over simultaneous clear, channel 1
    busWrite(A_CTRL, 32'd2);
    busWrite(A_MCTL, 32'h8);
    busWrite(A_MR0 + 4'd1, 32'd8);
    busWrite(A_CTRL, 32'd1);
    repeat (8) @(negedge clk);
    busAddr = A_IRQ; busWData = 32'h2; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    busRead(A_IRQ, rd); check("R9 set wins", rd, 32'h2);

    // R7 reset on match: PR=1, MR0=3
    busWrite(A_CTRL, 32'd2);
    busWrite(A_MCTL, 32'h2);
    busWrite(A_MR0, 32'd3);
    busWrite(A_PRE, 32'd1);
    busWrite(A_CTRL, 32'd1);
    repeat (7) @(negedge clk);
    busRead(A_TC, rd); check("R7 tc at match", rd, 32'd3);
    @(negedge clk);
    busRead(A_TC, rd); check("R7 tc wrapped", rd, 32'd0);
    repeat (5) @(negedge clk);
    busRead(A_TC, rd); check("R7 second period", rd, 32'd2);

    // R8 stop on match channel 3 with interrupt
    busWrite(A_IRQ, 32'hF);
    busWrite(A_CTRL, 32'd2);
    busWrite(A_MCTL, 32'hA00);
    busWrite(A_MR0 + 4'd3, 32'd4);
    busWrite(A_PRE, 32'd0);
    busWrite(A_CTRL, 32'd1);
    repeat (10) @(negedge clk);
    busRead(A_TC, rd);   check("R8 tc held", rd, 32'd4);
    busRead(A_CTRL, rd); check("R8 enable cleared", rd, 32'd0);
    busRead(A_IRQ, rd);  check("R8 flag ch3", rd, 32'h8);
    check("R10 irqOut ch3", {31'd0, irqOut}, 32'd1);

    // R4 counter clear overrides enable
    busWrite(A_MCTL, 32'd0);
    busWrite(A_TC, 32'd77);
    busWrite(A_PC, 32'd2);
    busWrite(A_CTRL, 32'd3);
    @(negedge clk);
    busRead(A_TC, rd); check("R4 tc cleared", rd, 32'd0);
    busRead(A_PC, rd); check("R4 pc cleared", rd, 32'd0);
    repeat (5) @(negedge clk);
    busRead(A_TC, rd); check("R4 tc still 0", rd, 32'd0);
    busWrite(A_CTRL, 32'd1);
    repeat (3) @(negedge clk);
    busRead(A_TC, rd); check("R4 resume count", rd, 32'd3);

    finishRun();
  end
endmodule